// File: doc/BRIEF.md
# Dual-Channel Disk Card Register Decoder

This block sits between a host expansion bus and the register space of a disk-interface card that carries two drive channels. It examines each byte access and decides where it goes. An access may reach one of eight taskfile registers on either channel, or a channel's alternate-status/device-control register. It may read one bit of the card's 4-bit identification code, or it may write the card's select register. An access that matches none of these is left undecoded.

All decoding is combinational from the bus address and the read and write strobes. For every decoded drive access, the block asserts a single chip select and supplies a 3-bit register index. Strobes and write data pass straight through to the drive side, and read data from the drive returns on the bus. The select register is the only state in the block. It is write-only and holds two bits. The first enables the fast register region, and taskfile and control accesses decode only while it is set. The second picks which channel receives the DMA request/acknowledge pair. Every pin is a plain control or data pin. There is no streamed data path, so no valid/ready handshake applies.

Top module: `ecd_card_decoder`

## Requirements
- R1: After reset the select register is 0, so `fast_en` and `dma_ch` are both 0.
- R2: A write strobe at address 0x0000 loads the select register on the next clock edge. Data bit 5 sets `fast_en` and data bit 0 sets `dma_ch`. The other data bits have no effect. Writing 0 clears both outputs. A write to any other address leaves the register unchanged.
- R3: A read at 0x2280 + 4·k (k = 0..3) returns identification strap bit k in data bit 0, with bits 7..1 at 0. The code is stored least significant bit first. It reads the same whether `fast_en` is 0 or 1, and no drive select is asserted.
- R4: With `fast_en` = 1, an access at 0x2000 + (n << 6) (n = 0..7) asserts `cs_tf[0]` and drives `drv_reg` = n.
- R5: With `fast_en` = 1, an access at 0x3000 + (n << 6) asserts `cs_tf[1]` and drives `drv_reg` = n.
- R6: With `fast_en` = 1, an access at 0x2380 asserts `cs_ctl[0]` and an access at 0x3380 asserts `cs_ctl[1]`. In both cases `drv_reg` = 6.
- R7: With `fast_en` = 0, no chip select is asserted at any address, and reads outside the identification locations return 0xFF.
- R8: Any address outside all decoded windows asserts no select and reads as 0xFF. This covers offsets inside a channel span that are not multiples of 64, and the select-register address itself.
- R9: Chip selects, `drv_rd` and `drv_wr` assert only while the matching bus strobe is high. `drv_wdata` follows `bus_wdata`. A read that hits a chip select returns `drv_rdata` on `bus_rdata`.
- R10: At most one chip select is asserted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 14 | Byte address within the card space |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte |
| id_strap | input | 4 | Card identification code (3 = dual channel, 15 = single channel) |
| drv_rdata | input | 8 | Read data returned by the selected drive register |
| drv_wdata | output | 8 | Write data to the drive |
| drv_rd | output | 1 | Drive read strobe |
| drv_wr | output | 1 | Drive write strobe |
| drv_reg | output | 3 | Register index within the selected bank |
| cs_tf | output | 2 | Per-channel taskfile chip select |
| cs_ctl | output | 2 | Per-channel alternate-control chip select |
| fast_en | output | 1 | Fast register region enabled |
| dma_ch | output | 1 | Channel receiving the DMA signals |

## Verification
Random addresses are mixed with addresses drawn from each window. Hitting every exact register location separates the two channels, the eight register indices and the control registers from one another. Addresses one to 63 bytes past a register boundary show that the 64-byte spacing is decoded exactly and not by masking. The same windows are accessed with the fast region both disabled and enabled, which separates gating from decoding. Select-register writes with random data bytes show that only bits 5 and 0 are kept. Identification reads under varied strap codes, including 3 and 15, confirm the bit order and that the code stays readable while the region is gated off.

// File: rtl/ecd_pkg.sv
package ecd_pkg;
  localparam int ADDR_W   = 14;
  localparam int DATA_W   = 8;
  localparam int NUM_CH   = 2;
  localparam int NREG     = 8;
  localparam int IDX_W    = $clog2(NREG);
  localparam int REG_SHFT = 6;
  localparam int TF_BASE0 = 'h2000;
  localparam int CH_STRD  = 'h1000;
  localparam int CTL_OFF  = 'h380;
  localparam int CTL_IDX  = 6;
  localparam int ID_BASE  = 'h2280;
  localparam int ID_SHFT  = 2;
  localparam int ID_W     = 4;
  localparam int SEL_ADDR = 'h0000;
  localparam int FAST_BIT = 5;
  localparam int DMA_BIT  = 0;

  typedef struct packed {
    logic             tf;
    logic             ctl;
    logic [IDX_W-1:0] idx;
  } win_hit_t;

  function automatic int chan_base(input int ch);
    return TF_BASE0 + ch * CH_STRD;
  endfunction
endpackage

// File: rtl/ecd_chan_win.sv
module ecd_chan_win
  import ecd_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int BASE  = TF_BASE0,
  parameter int SHFT  = REG_SHFT,
  parameter int NR    = NREG,
  parameter int COFF  = CTL_OFF
) (
  input  logic [AW-1:0] addr,
  output win_hit_t      hit
);
  localparam int IW = $clog2(NR);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW-1:0] SPAN_A = AW'(NR << SHFT);
  localparam logic [AW-1:0] COFF_A = AW'(COFF);

  logic [AW-1:0] off;

  always_comb begin
    off     = addr - BASE_A;
    hit.tf  = (off < SPAN_A) && (off[SHFT-1:0] == '0);
    hit.ctl = (off == COFF_A);
    hit.idx = off[SHFT +: IW];
  end
endmodule

// File: rtl/ecd_id_port.sv
module ecd_id_port
  import ecd_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int BASE = ID_BASE,
  parameter int SHFT = ID_SHFT,
  parameter int IW   = ID_W
) (
  input  logic [AW-1:0] addr,
  input  logic [IW-1:0] strap,
  output logic          hit,
  output logic          bit_val
);
  localparam int KW = (IW > 1) ? $clog2(IW) : 1;
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW-1:0] SPAN_A = AW'(IW << SHFT);

  logic [AW-1:0] off;
  logic [KW-1:0] k;

  always_comb begin
    off     = addr - BASE_A;
    hit     = (off < SPAN_A) && (off[SHFT-1:0] == '0);
    k       = off[SHFT +: KW];
    bit_val = hit ? strap[k] : 1'b0;
  end
endmodule

// File: rtl/ecd_sel_reg.sv
module ecd_sel_reg
  import ecd_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int ADR = SEL_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          fast_in,
  input  logic          dma_in,
  output logic          fast_q,
  output logic          dma_q
);
  localparam logic [AW-1:0] ADR_A = AW'(ADR);

  logic load;
  assign load = wr && (addr == ADR_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      dma_q  <= 1'b0;
    end else if (load) begin
      fast_q <= fast_in;
      dma_q  <= dma_in;
    end
  end

  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_A) |=> (fast_q == $past(fast_in)) && (dma_q == $past(dma_in)));
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADR_A) |=> $stable(fast_q) && $stable(dma_q));
endmodule

// File: rtl/ecd_card_decoder.sv
module ecd_card_decoder
  import ecd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ID_W-1:0]   id_strap,
  input  logic [DATA_W-1:0] drv_rdata,
  output logic [DATA_W-1:0] drv_wdata,
  output logic              drv_rd,
  output logic              drv_wr,
  output logic [IDX_W-1:0]  drv_reg,
  output logic [NUM_CH-1:0] cs_tf,
  output logic [NUM_CH-1:0] cs_ctl,
  output logic              fast_en,
  output logic              dma_ch
);
  win_hit_t          hits [NUM_CH];
  logic              strobe;
  logic              any_cs;
  logic              id_hit;
  logic              id_bit;

  assign strobe = bus_rd | bus_wr;

  ecd_sel_reg #(.AW(ADDR_W), .ADR(SEL_ADDR)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .fast_in (bus_wdata[FAST_BIT]),
    .dma_in  (bus_wdata[DMA_BIT]),
    .fast_q  (fast_en),
    .dma_q   (dma_ch)
  );

  ecd_id_port #(.AW(ADDR_W), .BASE(ID_BASE), .SHFT(ID_SHFT), .IW(ID_W)) u_id (
    .addr    (bus_addr),
    .strap   (id_strap),
    .hit     (id_hit),
    .bit_val (id_bit)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ecd_chan_win #(
      .AW   (ADDR_W),
      .BASE (chan_base(ch)),
      .SHFT (REG_SHFT),
      .NR   (NREG),
      .COFF (CTL_OFF)
    ) u_win (
      .addr (bus_addr),
      .hit  (hits[ch])
    );
    assign cs_tf[ch]  = fast_en && strobe && hits[ch].tf;
    assign cs_ctl[ch] = fast_en && strobe && hits[ch].ctl;
  end

  always_comb begin
    drv_reg = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (cs_tf[ch])  drv_reg = hits[ch].idx;
      if (cs_ctl[ch]) drv_reg = IDX_W'(CTL_IDX);
    end
  end

  assign any_cs    = |{cs_tf, cs_ctl};
  assign drv_rd    = bus_rd && any_cs;
  assign drv_wr    = bus_wr && any_cs;
  assign drv_wdata = bus_wdata;

  always_comb begin
    if (bus_rd && any_cs)      bus_rdata = drv_rdata;
    else if (bus_rd && id_hit) bus_rdata = {{(DATA_W-1){1'b0}}, id_bit};
    else                       bus_rdata = '1;
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_tf, cs_ctl}));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> (cs_tf == '0) && (cs_ctl == '0) && !drv_rd && !drv_wr);
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |-> (cs_tf == '0) && (cs_ctl == '0));
  p_id_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && id_hit) |-> (bus_rdata[DATA_W-1:1] == '0) && (cs_tf == '0));
  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !fast_en && !dma_ch);
endmodule

// File: tb/ecd_card_decoder_tb_top.sv
module ecd_card_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [3:0]  id_strap = 4'd3;
  logic [7:0]  drv_rdata = '0, drv_wdata;
  logic        drv_rd, drv_wr, fast_en, dma_ch;
  logic [2:0]  drv_reg;
  logic [1:0]  cs_tf, cs_ctl;

  int n_run = 0, n_fail = 0;
  bit m_fast = 0, m_dma = 0;

  always #10 clk = ~clk;

  ecd_card_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .id_strap(id_strap),
    .drv_rdata(drv_rdata), .drv_wdata(drv_wdata), .drv_rd(drv_rd), .drv_wr(drv_wr),
    .drv_reg(drv_reg), .cs_tf(cs_tf), .cs_ctl(cs_ctl), .fast_en(fast_en), .dma_ch(dma_ch)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected decode from the requirements: {cs_tf, cs_ctl, reg, rdata}
  function automatic logic [14:0] model(input logic [13:0] a, input bit rd, input bit wr,
                                        input bit fast, input logic [3:0] strap,
                                        input logic [7:0] dr);
    logic [1:0] tf = 0, ctl = 0;
    logic [2:0] rg = 0;
    logic [7:0] rdv = 8'hFF;
    for (int ch = 0; ch < 2; ch++) begin
      int base = 'h2000 + ch * 'h1000;
      for (int n = 0; n < 8; n++)
        if (int'(a) == base + (n << 6)) begin tf[ch] = 1; rg = 3'(n); end
      if (int'(a) == base + 'h380) begin ctl[ch] = 1; rg = 3'd6; end
    end
    if (!(fast && (rd || wr))) begin tf = 0; ctl = 0; rg = 0; end
    if (rd && (tf != 0 || ctl != 0)) rdv = dr;
    else if (rd)
      for (int k = 0; k < 4; k++)
        if (int'(a) == 'h2280 + 4 * k) rdv = {7'b0, strap[k]};
    return {tf, ctl, rg, rdv};
  endfunction

  function automatic string tag_of(input logic [13:0] a, input bit fast);
    if (int'(a) >= 'h2280 && int'(a) <= 'h228C) return "R3";
    if (!fast) return "R7";
    if (int'(a) == 'h2380 || int'(a) == 'h3380) return "R6";
    if (int'(a) >= 'h3000 && int'(a) < 'h3200) return "R5";
    if (int'(a) >= 'h2000 && int'(a) < 'h2200) return "R4";
    return "R8";
  endfunction

  task automatic access(input logic [13:0] a, input bit rd, input bit wr, input logic [7:0] wd);
    logic [14:0] e;
    string t;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; drv_rdata = 8'($urandom);
    #2;
    e = model(a, rd, wr, m_fast, id_strap, drv_rdata);
    t = tag_of(a, m_fast);
    check(t, {cs_tf, cs_ctl, drv_reg, bus_rdata}, e);
    check("R9", {drv_rd, drv_wr, drv_wdata},
          {rd && (e[14:11] != 0), wr && (e[14:11] != 0), wd});
    check("R10", 32'($countones({cs_tf, cs_ctl}) <= 1), 1);
    @(posedge clk);
    if (wr && a == 14'h0000) begin m_fast = wd[5]; m_dma = wd[0]; end
    #1;
    bus_rd = 0; bus_wr = 0;
    check("R2", {fast_en, dma_ch}, {m_fast, m_dma});
  endtask

  function automatic logic [13:0] pick_addr();
    int s = $urandom_range(0, 5);
    case (s)
      0: return 14'('h2000 + ($urandom_range(0, 7) << 6));
      1: return 14'('h3000 + ($urandom_range(0, 7) << 6));
      2: return $urandom_range(0, 1) ? 14'h2380 : 14'h3380;
      3: return 14'('h2280 + 4 * $urandom_range(0, 3));
      4: return 14'('h2000 + ($urandom_range(0, 1) << 12) + $urandom_range(1, 511));
      default: return 14'($urandom);
    endcase
  endfunction

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {fast_en, dma_ch}, 2'b00);
    rst_n = 1;
    // R7: windows gated off while select register is 0
    access(14'h2000, 1, 0, 0);
    access(14'h3380, 0, 1, 8'h55);
    access(14'h2284, 1, 0, 0);       // R3 readable when gated
    // R2: only bit 5 and bit 0 kept
    access(14'h0000, 0, 1, 8'hDE);   // bit5=0, bit0=0
    access(14'h0000, 0, 1, 8'h21);   // enable fast, dma ch1
    access(14'h0000, 1, 0, 0);       // R8 read of select address
    // R4, R5, R6 exact locations
    for (int n = 0; n < 8; n++) begin
      access(14'('h2000 + (n << 6)), 1, 0, 0);
      access(14'('h3000 + (n << 6)), 0, 1, 8'(n));
    end
    access(14'h2380, 1, 0, 0);
    access(14'h3380, 0, 1, 8'h0C);
    // R8 off-grid and gaps
    access(14'h2001, 1, 0, 0);
    access(14'h303F, 1, 0, 0);
    access(14'h2200, 1, 0, 0);
    access(14'h2281, 1, 0, 0);
    // R9: no strobe means no select
    access(14'h2040, 0, 0, 0);
    // R3 with codes 3 and 15
    foreach (id_strap[k]) begin end
    id_strap = 4'd15;
    for (int k = 0; k < 4; k++) access(14'('h2280 + 4 * k), 1, 0, 0);
    id_strap = 4'd3;
    for (int k = 0; k < 4; k++) access(14'('h2280 + 4 * k), 1, 0, 0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) access(14'h0000, 0, 1, 8'($urandom));
      else begin
        if (op == 1) id_strap = 4'($urandom);
        access(pick_addr(), $urandom_range(0, 1) == 1, op > 6, 8'($urandom));
      end
    end
    // R2: writing zero clears both
    access(14'h0000, 0, 1, 8'h21);
    access(14'h0000, 0, 1, 8'h00);
    access(14'h2040, 1, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule